// File: doc/BRIEF.md
# Servo pulse PWM generator

This block drives a hobby-servo control line. A frame counter advances once per microsecond tick and closes a 20000-count frame (50 Hz). Within each frame the line stays low at first and rises for the final stretch. The length of that high stretch equals the commanded pulse width in microseconds. Position commands arrive as an unsigned microsecond value. They are limited to the range 1000..2000 µs: 1000 is the far-left end of travel, 1500 the middle and 2000 the far-right end.

A command is first captured in a pending register. It reaches the register that shapes the output only when the counter rolls over. As a result, every frame is built from a single, whole pulse width. Counting pauses whenever the enable input is low. Reaching a threshold never halts the counter. A one-cycle-per-frame marker shows when the counter sits at zero.

Top module: `servo_pulse_gen`

## Requirements
- R1: The frame counter moves forward by one only on a clock edge where both `tick_1mhz` and `en` are high. Otherwise it holds, and so do `pwm_out` and `frame_start`.
- R2: The counter covers the values 0..FRAME_LEN-1 and returns to 0 on the advance after FRAME_LEN-1. A frame is therefore FRAME_LEN advances long (20000 by default).
- R3: Let W be the active width. `pwm_out` is 0 while the counter is below FRAME_LEN-W and 1 from FRAME_LEN-W through FRAME_LEN-1. This gives exactly W high advances, placed at the end of each frame.
- R4: A command below MIN_US (1000) is stored as MIN_US.
- R5: A command above MAX_US (2000) is stored as MAX_US. Commands inside the range are stored unchanged.
- R6: While `rst_n` is low at a clock edge, the counter is cleared to 0, `pwm_out` is driven low, and both the pending and active widths are set to RESET_US (1500).
- R7: A command written with `cmd_valid` does not change the frame in progress. It governs the frame that starts at the next rollover.
- R8: `frame_start` is 1 exactly while the counter is 0.
- R9: When several commands are written within one frame, the last one written before the rollover is the one that applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1mhz | input | 1 | Count enable pulse, one per microsecond |
| en | input | 1 | Run enable; counting stops while low |
| cmd_valid | input | 1 | Strobe that captures `cmd_us` |
| cmd_us | input | CMD_W (12) | Requested pulse width in microseconds, unsigned |
| pwm_out | output | 1 | Servo control pulse |
| frame_start | output | 1 | High while the frame counter is 0 |

## Verification
The assertions assume that the parameters are consistent: MIN_US <= RESET_US <= MAX_US < FRAME_LEN, and MAX_US fits in CMD_W bits. They also assume that `tick_1mhz` and `en` are plain levels sampled on each edge. Nothing is assumed about `cmd_us`, so every code, legal or not, may reach the clamp. The stimulus uses a small frame that still meets these parameter bounds. It sweeps every command code and varies the tick and enable levels freely, including pauses in the middle of a frame. Reset is applied only as a whole-cycle level.

// File: rtl/servo_pwm_pkg.sv
// Package: shared defaults and the width-limiting function for the servo pulse generator.
// Assumes callers pass bounds with lo <= hi.
package servo_pwm_pkg;

    localparam int unsigned DEF_FRAME_LEN = 20000;
    localparam int unsigned DEF_MIN_US    = 1000;
    localparam int unsigned DEF_MAX_US    = 2000;
    localparam int unsigned DEF_RESET_US  = 1500;
    localparam int unsigned DEF_CMD_W     = 12;

    // Limit a requested width to the closed range [lo, hi].
    function automatic int unsigned limit_width(int unsigned v, int unsigned lo, int unsigned hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/servo_cmd_clamp.sv
// Module: limits a raw microsecond command to the legal servo range.
// Purely combinational. Assumes MAX_US fits in CMD_W bits.
module servo_cmd_clamp #(
    parameter int unsigned CMD_W  = servo_pwm_pkg::DEF_CMD_W,
    parameter int unsigned MIN_US = servo_pwm_pkg::DEF_MIN_US,
    parameter int unsigned MAX_US = servo_pwm_pkg::DEF_MAX_US
) (
    input  logic [CMD_W-1:0] raw_i,
    output logic [CMD_W-1:0] width_o
);

    // Map the incoming code onto [MIN_US, MAX_US].
    always_comb begin
        width_o = CMD_W'(servo_pwm_pkg::limit_width(32'(raw_i), MIN_US, MAX_US));
    end

endmodule

// File: rtl/servo_frame_counter.sv
// Module: frame counter that runs from 0 to FRAME_LEN-1 and then rolls over.
// Moves only when adv_i is high. Assumes CNT_W can hold FRAME_LEN-1.
module servo_frame_counter #(
    parameter int unsigned FRAME_LEN = servo_pwm_pkg::DEF_FRAME_LEN,
    parameter int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = adv_i && (cnt_q == LAST);
    assign cnt_o  = cnt_q;

    // Step the count on each advance and restart it at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wrap_o) cnt_q <= '0;
        else if (adv_i)  cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/servo_width_regs.sv
// Module: pending and active pulse-width registers.
// The pending register takes every strobed command. The active register copies it
// only on a rollover, so no frame mixes two widths.
module servo_width_regs #(
    parameter int unsigned CMD_W    = servo_pwm_pkg::DEF_CMD_W,
    parameter int unsigned RESET_US = servo_pwm_pkg::DEF_RESET_US
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CMD_W-1:0] width_i,
    input  logic             wrap_i,
    output logic [CMD_W-1:0] active_o
);

    localparam logic [CMD_W-1:0] RST_W = CMD_W'(RESET_US);

    logic [CMD_W-1:0] pend_q;
    logic [CMD_W-1:0] act_q;

    // Capture each limited command into the pending register.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= RST_W;
        else if (load_i) pend_q <= width_i;
    end

    // Move the pending width into use at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= RST_W;
        else if (wrap_i) act_q <= pend_q;
    end

    assign active_o = act_q;

endmodule

// File: rtl/servo_pulse_compare.sv
// Module: compares the frame count with the rise threshold (frame length minus width).
// Output is combinational from registered state, so it is glitch-free per cycle.
module servo_pulse_compare #(
    parameter int unsigned FRAME_LEN = servo_pwm_pkg::DEF_FRAME_LEN,
    parameter int unsigned CNT_W     = $clog2(FRAME_LEN),
    parameter int unsigned CMD_W     = servo_pwm_pkg::DEF_CMD_W
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CMD_W-1:0] width_i,
    output logic             pwm_o,
    output logic             start_o
);

    localparam int unsigned MW = ((CNT_W > CMD_W) ? CNT_W : CMD_W) + 1;

    logic [MW-1:0] rise_at;

    // The line is high from the rise threshold to the end of the frame.
    always_comb begin
        rise_at = MW'(FRAME_LEN) - MW'(width_i);
        pwm_o   = MW'(cnt_i) >= rise_at;
        start_o = (cnt_i == '0);
    end

endmodule

// File: rtl/servo_pulse_gen.sv
// Module: top level of the servo pulse generator.
// Assumes MIN_US <= RESET_US <= MAX_US < FRAME_LEN and that MAX_US fits in CMD_W bits.
// The counter moves on each clock edge where tick_1mhz and en are both high.
module servo_pulse_gen #(
    parameter int unsigned FRAME_LEN = servo_pwm_pkg::DEF_FRAME_LEN,
    parameter int unsigned MIN_US    = servo_pwm_pkg::DEF_MIN_US,
    parameter int unsigned MAX_US    = servo_pwm_pkg::DEF_MAX_US,
    parameter int unsigned RESET_US  = servo_pwm_pkg::DEF_RESET_US,
    parameter int unsigned CMD_W     = servo_pwm_pkg::DEF_CMD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1mhz,
    input  logic             en,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_us,
    output logic             pwm_out,
    output logic             frame_start
);

    localparam int unsigned CNT_W = $clog2(FRAME_LEN);

    logic             adv;
    logic             wrap;
    logic [CNT_W-1:0] cnt_q;
    logic [CMD_W-1:0] lim_w;
    logic [CMD_W-1:0] act_w;

    assign adv = tick_1mhz && en;

    servo_cmd_clamp #(.CMD_W(CMD_W), .MIN_US(MIN_US), .MAX_US(MAX_US)) u_clamp (
        .raw_i   (cmd_us),
        .width_o (lim_w)
    );

    servo_frame_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv),
        .cnt_o  (cnt_q),
        .wrap_o (wrap)
    );

    servo_width_regs #(.CMD_W(CMD_W), .RESET_US(RESET_US)) u_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cmd_valid),
        .width_i  (lim_w),
        .wrap_i   (wrap),
        .active_o (act_w)
    );

    servo_pulse_compare #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W), .CMD_W(CMD_W)) u_cmp (
        .cnt_i   (cnt_q),
        .width_i (act_w),
        .pwm_o   (pwm_out),
        .start_o (frame_start)
    );

endmodule

// File: rtl/servo_pulse_gen_chk.sv
// Module: property checker for servo_pulse_gen, bound to every instance of it.
// Watches the frame count and the active width through bound internal nets.
module servo_pulse_gen_chk #(
    parameter int unsigned FRAME_LEN = 20000,
    parameter int unsigned MIN_US    = 1000,
    parameter int unsigned MAX_US    = 2000,
    parameter int unsigned RESET_US  = 1500,
    parameter int unsigned CMD_W     = 12,
    parameter int unsigned CNT_W     = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_1mhz,
    input logic             en,
    input logic             pwm_out,
    input logic             frame_start,
    input logic [CNT_W-1:0] cnt,
    input logic [CMD_W-1:0] act_w
);

    localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CMD_W-1:0] LO_W  = CMD_W'(MIN_US);
    localparam logic [CMD_W-1:0] HI_W  = CMD_W'(MAX_US);
    localparam logic [CMD_W-1:0] RST_W = CMD_W'(RESET_US);
    localparam int unsigned      MW    = ((CNT_W > CMD_W) ? CNT_W : CMD_W) + 1;

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_1mhz && en) |=> $stable(cnt));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1mhz && en && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1mhz && en && cnt == LAST) |=> (cnt == '0));

    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (MW'(cnt) == MW'(FRAME_LEN) - MW'(act_w)));

    p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> (cnt == '0));

    p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_w >= LO_W);

    p_ceil_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_w <= HI_W);

    p_reset_r6: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && act_w == RST_W && !pwm_out));

    p_frame_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_1mhz && en && cnt == LAST) |=> $stable(act_w));

    p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !pwm_out);

endmodule

bind servo_pulse_gen servo_pulse_gen_chk #(
    .FRAME_LEN (FRAME_LEN),
    .MIN_US    (MIN_US),
    .MAX_US    (MAX_US),
    .RESET_US  (RESET_US),
    .CMD_W     (CMD_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1mhz   (tick_1mhz),
    .en          (en),
    .pwm_out     (pwm_out),
    .frame_start (frame_start),
    .cnt         (cnt_q),
    .act_w       (act_w)
);

// File: tb/sim_servo_pulse_gen.sv
// Bench: small-frame configuration, exhaustive command sweep, reference computed from the requirements.
module sim_servo_pulse_gen;

    localparam int L  = 40;
    localparam int LO = 8;
    localparam int HI = 16;
    localparam int RS = 12;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1mhz = 1'b0;
    logic          en = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [CW-1:0] cmd_us = '0;
    logic          pwm_out;
    logic          frame_start;

    int checks = 0;
    int fails  = 0;
    int pos = 0;
    int act = RS;
    int shd = RS;

    always #10 clk = ~clk;

    servo_pulse_gen #(.FRAME_LEN(L), .MIN_US(LO), .MAX_US(HI), .RESET_US(RS), .CMD_W(CW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_1mhz   (tick_1mhz),
        .en          (en),
        .cmd_valid   (cmd_valid),
        .cmd_us      (cmd_us),
        .pwm_out     (pwm_out),
        .frame_start (frame_start)
    );

    function automatic int lim(int v);
        return (v < LO) ? LO : ((v > HI) ? HI : v);
    endfunction

    task automatic chk(bit ok, string tag, int a, int e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, a, e, $time);
        end
    endtask

    // One clock: drive at the falling edge, update the reference at the rising edge, compare at the next falling edge.
    task automatic step(bit tk, bit e, bit v, int c, string tag);
        int nsh;
        tick_1mhz = tk; en = e; cmd_valid = v; cmd_us = CW'(c);
        @(posedge clk);
        nsh = v ? lim(c) : shd;
        if (tk && e) begin
            if (pos == L - 1) begin pos = 0; act = shd; end
            else pos++;
        end
        shd = nsh;
        @(negedge clk);
        chk(pwm_out == (pos >= L - act), tag, int'(pwm_out), int'(pos >= L - act));
        chk(frame_start == (pos == 0), "R8", int'(frame_start), int'(pos == 0));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_1mhz = 1'b1; en = 1'b1; cmd_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pwm_out == 1'b0, "R6 pwm", int'(pwm_out), 0);
        chk(frame_start == 1'b1, "R6 start", int'(frame_start), 1);
        rst_n = 1'b1;
        pos = 0; act = RS; shd = RS;
    endtask

    // Run one full frame from count 0 with the tick always on; optionally write a command at position 2.
    task automatic run_frame(int c, bit wr, output int highs);
        bit early = 1'b0;
        highs = 0;
        for (int i = 0; i < L; i++) begin
            step(1'b1, 1'b1, wr && (i == 2), c, "R3");
            if (pwm_out) highs++;
            if (i < L - 1 && frame_start) early = 1'b1;
        end
        chk(frame_start && !early, "R2 frame length", int'(early), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int h;
        int prev;
        int prevc;
        @(negedge clk);
        do_reset();

        // R6: first frame after reset uses the reset width.
        run_frame(0, 1'b0, h);
        chk(h == RS, "R6 width", h, RS);

        // Sweep every command code; each frame must still show the previous width (R7).
        prev = RS; prevc = RS;
        for (int c = 0; c < (1 << CW); c++) begin
            run_frame(c, 1'b1, h);
            if (prevc < LO)      chk(h == prev, "R7,R4", h, prev);
            else if (prevc > HI) chk(h == prev, "R7,R5", h, prev);
            else                 chk(h == prev, "R7,R3", h, prev);
            prev = lim(c); prevc = c;
        end
        run_frame(0, 1'b0, h);
        chk(h == HI, "R5 top code", h, HI);

        // R9: two writes in one frame, the later one applies.
        for (int i = 0; i < L; i++) step(1'b1, 1'b1, (i == 2) || (i == 5), (i == 2) ? 9 : 14, "R9");
        run_frame(0, 1'b0, h);
        chk(h == 14, "R9 last write", h, 14);

        // R1: irregular ticks and enable drops; the reference tracks only the qualified advances.
        for (int i = 0; i < 3 * L; i++) step(i % 3 != 2, i % 7 != 0, i == 11, 3, "R1");
        begin
            logic p0, s0;
            p0 = pwm_out; s0 = frame_start;
            for (int i = 0; i < 10; i++) begin
                step(1'b1, 1'b0, 1'b0, 0, "R1");
                chk(pwm_out == p0 && frame_start == s0, "R1 hold", int'(pwm_out), int'(p0));
            end
        end
        while (pos != 0) step(1'b1, 1'b1, 1'b0, 0, "R1");
        run_frame(0, 1'b0, h);
        chk(h == LO, "R1,R4 after gating", h, LO);

        // R6: reset in mid-frame restores the reset width.
        run_frame(60, 1'b1, h);
        for (int i = 0; i < 25; i++) step(1'b1, 1'b1, 1'b0, 0, "R3");
        do_reset();
        run_frame(0, 1'b0, h);
        chk(h == RS, "R6 mid-frame reset", h, RS);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule